// File: doc/BRIEF.md
# PS/2 Wake and Isolation Logic

This block sits between the keyboard and mouse port pins and the PS/2 keyboard controller core. Each port has an isolation bit. When the bit is set, the clock and data lines into the core are held at their idle-high level. The wake detector always sees the raw pin data. The block also holds each interrupt from the core in a latch and presents it in one of two selectable forms.

The block watches for wake events and records them in sticky status bits. A keyboard event is a keyboard interrupt or a falling edge on the keyboard data pin. A mouse event is a mouse interrupt or a falling edge on the mouse data pin. A power-management event (`pme`) is raised when a status bit, its wake-enable bit and the global enable are all set.

Data-edge events work on standby power alone. Interrupt events count only while main power is good. Isolation, status and enable state is cleared only by the standby reset. Latch modes, interrupt latches and the controller-core reset bit belong to the main domain. A single write port (`wr_en`, `wr_sel`, `wr_data`) reaches five registers.

Top module: `kbm_wake_iso`

## Requirements
- R1: Writing the isolation register (`wr_sel`=0) controls the core lines. Bit 5 set forces `core_kbd_clk` and `core_kbd_dat` to 1, and bit 6 set does the same for the mouse lines. With a bit clear, the core lines follow the pins. The change takes effect from the write edge onward.
- R2: Isolation never blocks the data pins into the wake detector. A data fall on an isolated port still sets its status bit.
- R3: The isolation bits and the wake status survive `main_rst`. Only `sb_rst` clears them.
- R4: The latch-mode register (`wr_sel`=1) holds one bit per port: bit 3 for the keyboard, bit 4 for the mouse. Both bits are 0 after `main_rst`. With the bit at 0, the interrupt output is the raw interrupt ANDed with its latched copy. A raw interrupt sets the latch at the next edge.
- R5: With the latch-mode bit at 1, the interrupt output is the latched copy alone and stays high after the raw interrupt drops. An ack pulse clears the latch at the next edge. Ack has priority over a raw interrupt in the same cycle.
- R6: A data pin passes through two synchronizer flops. A falling edge on the synchronized signal sets the wake status bit: bit 3 of `wake_sts` for the keyboard, bit 4 for the mouse. A data pin held low through `sb_rst` counts as a falling edge once reset is released.
- R7: A rising raw interrupt sets its port's status bit only while `main_pwr_ok` is 1. Data-edge events set status regardless of `main_pwr_ok`.
- R8: Status bits are write-one-to-clear through `wr_sel`=2, using bits 3 and 4. An event in the same cycle as a clear leaves the bit set.
- R9: The enable register (`wr_sel`=3) holds the global enable in bit 0, the keyboard wake enable in bit 3 and the mouse wake enable in bit 4. `pme` is 1 exactly when the global enable is set and some status bit has its own enable bit set.
- R10: The control register (`wr_sel`=4) drives `core_rst` from bit 6. Writing 0x40 sets it, and it stays set through writes to other registers until 0x00 is written. `main_rst` clears it.
- R11: After both resets, with the pins high, `wake_sts`, `pme`, `core_rst`, `kbd_irq` and `mouse_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sb_rst | input | 1 | Standby-supply power-on reset, synchronous active high |
| main_rst | input | 1 | Main-supply reset, synchronous active high |
| main_pwr_ok | input | 1 | Main supply good; gates interrupt wake events |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 isolation, 1 latch mode, 2 status, 3 enable, 4 control) |
| wr_data | input | 8 | Write data |
| kbd_clk_pin | input | 1 | Keyboard clock pin |
| kbd_dat_pin | input | 1 | Keyboard data pin |
| mouse_clk_pin | input | 1 | Mouse clock pin |
| mouse_dat_pin | input | 1 | Mouse data pin |
| core_kbd_clk | output | 1 | Keyboard clock into controller core |
| core_kbd_dat | output | 1 | Keyboard data into controller core |
| core_mouse_clk | output | 1 | Mouse clock into controller core |
| core_mouse_dat | output | 1 | Mouse data into controller core |
| kbd_irq_raw | input | 1 | Keyboard interrupt from the core |
| mouse_irq_raw | input | 1 | Mouse interrupt from the core |
| kbd_irq_ack | input | 1 | Clears the keyboard interrupt latch |
| mouse_irq_ack | input | 1 | Clears the mouse interrupt latch |
| kbd_irq | output | 1 | Keyboard interrupt output |
| mouse_irq | output | 1 | Mouse interrupt output |
| core_rst | output | 1 | Controller-core reset |
| wake_sts | output | 8 | Wake status image (bit 3 keyboard, bit 4 mouse) |
| pme | output | 1 | Power-management event |

## Verification
The assertions rely on a few properties of the inputs:
- `sb_rst` and `main_rst` are synchronous and both asserted at power-up.
- Register writes are single-cycle strobes.
- An ack pulse comes on its own, without needing a raw interrupt to fall in the same cycle.

The bench drives every input on the falling clock edge. It applies both resets together before any scenario. It raises raw interrupts only from a low level, so that each rising edge is a distinct event. It holds each pin level for at least four edges so that the synchronizer settles before outputs are sampled.

// File: rtl/kbm_wake_pkg.sv
package kbm_wake_pkg;

    localparam int NPORT      = 2;
    localparam int PORT_KBD   = 0;
    localparam int PORT_MOUSE = 1;

    localparam int GLOBAL_EN_BIT = 0;
    localparam int CORE_RST_BIT  = 6;

    typedef enum logic [2:0] {
        SEL_ISO  = 3'd0,
        SEL_MODE = 3'd1,
        SEL_STS  = 3'd2,
        SEL_EN   = 3'd3,
        SEL_CTRL = 3'd4
    } kbm_sel_e;

    typedef struct packed {
        logic [NPORT-1:0] iso;
        logic [NPORT-1:0] mode;
        logic [NPORT-1:0] wake_en;
        logic             pme_en;
        logic             core_rst;
    } kbm_cfg_t;

    // isolation bit of a port in the isolation register
    function automatic int iso_bit(int p);
        return (p == PORT_KBD) ? 5 : 6;
    endfunction

    // per-port bit shared by status, enable and latch-mode registers
    function automatic int evt_bit(int p);
        return (p == PORT_KBD) ? 3 : 4;
    endfunction

    function automatic logic irq_view(logic mode, logic raw, logic lat);
        return mode ? lat : (raw & lat);
    endfunction

endpackage

// File: rtl/kbm_edge_sync.sv
module kbm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    localparam int W = STAGES + 1;

    logic [W-1:0] shreg;

    // all stages reset high so a pin held low shows up as a fall
    always_ff @(posedge clk) begin
        if (rst) shreg <= '1;
        else     shreg <= {shreg[W-2:0], din};
    end

    assign fall = shreg[W-1] & ~shreg[W-2];

endmodule

// File: rtl/kbm_irq_latch.sv
module kbm_irq_latch
    import kbm_wake_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode,
    input  logic raw,
    input  logic ack,
    output logic irq,
    output logic rise
);
    logic lat;
    logic raw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat   <= 1'b0;
            raw_q <= 1'b0;
        end else begin
            raw_q <= raw;
            if (ack)      lat <= 1'b0;
            else if (raw) lat <= 1'b1;
        end
    end

    assign irq  = irq_view(mode, raw, lat);
    assign rise = raw & ~raw_q;

endmodule

// File: rtl/kbm_wake_regs.sv
module kbm_wake_regs
    import kbm_wake_pkg::*;
(
    input  logic             clk,
    input  logic             sb_rst,
    input  logic             main_rst,
    input  logic             wr_en,
    input  kbm_sel_e         wr_sel,
    input  logic [7:0]       wr_data,
    input  logic [NPORT-1:0] evt,
    output kbm_cfg_t         cfg,
    output logic [NPORT-1:0] sts
);
    logic [NPORT-1:0] sts_nxt;
    logic             unused_bits;

    assign unused_bits = ^{wr_data[7], wr_data[2:1]};

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            sts_nxt[p] = evt[p] |
                (sts[p] & ~(wr_en && wr_sel == SEL_STS && wr_data[evt_bit(p)]));
        end
    end

    // standby domain
    always_ff @(posedge clk) begin
        if (sb_rst) begin
            cfg.iso     <= '0;
            cfg.wake_en <= '0;
            cfg.pme_en  <= 1'b0;
            sts         <= '0;
        end else begin
            sts <= sts_nxt;
            if (wr_en) begin
                case (wr_sel)
                    SEL_ISO: for (int p = 0; p < NPORT; p++)
                        cfg.iso[p] <= wr_data[iso_bit(p)];
                    SEL_EN: begin
                        for (int p = 0; p < NPORT; p++)
                            cfg.wake_en[p] <= wr_data[evt_bit(p)];
                        cfg.pme_en <= wr_data[GLOBAL_EN_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end

    // main domain
    always_ff @(posedge clk) begin
        if (main_rst) begin
            cfg.mode     <= '0;
            cfg.core_rst <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_MODE: for (int p = 0; p < NPORT; p++)
                    cfg.mode[p] <= wr_data[evt_bit(p)];
                SEL_CTRL: cfg.core_rst <= wr_data[CORE_RST_BIT];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/kbm_wake_iso.sv
module kbm_wake_iso
    import kbm_wake_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       sb_rst,
    input  logic       main_rst,
    input  logic       main_pwr_ok,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       kbd_clk_pin,
    input  logic       kbd_dat_pin,
    input  logic       mouse_clk_pin,
    input  logic       mouse_dat_pin,
    output logic       core_kbd_clk,
    output logic       core_kbd_dat,
    output logic       core_mouse_clk,
    output logic       core_mouse_dat,
    input  logic       kbd_irq_raw,
    input  logic       mouse_irq_raw,
    input  logic       kbd_irq_ack,
    input  logic       mouse_irq_ack,
    output logic       kbd_irq,
    output logic       mouse_irq,
    output logic       core_rst,
    output logic [7:0] wake_sts,
    output logic       pme
);
    kbm_cfg_t         cfg;
    logic [NPORT-1:0] pin_clk, pin_dat, out_clk, out_dat;
    logic [NPORT-1:0] irq_raw, irq_ack, irq_out, irq_rise;
    logic [NPORT-1:0] data_fall, evt, sts;

    assign pin_clk = {mouse_clk_pin, kbd_clk_pin};
    assign pin_dat = {mouse_dat_pin, kbd_dat_pin};
    assign irq_raw = {mouse_irq_raw, kbd_irq_raw};
    assign irq_ack = {mouse_irq_ack, kbd_irq_ack};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign out_clk[p] = cfg.iso[p] | pin_clk[p];
        assign out_dat[p] = cfg.iso[p] | pin_dat[p];

        kbm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (sb_rst),
            .din  (pin_dat[p]),
            .fall (data_fall[p])
        );

        kbm_irq_latch u_latch (
            .clk  (clk),
            .rst  (main_rst),
            .mode (cfg.mode[p]),
            .raw  (irq_raw[p]),
            .ack  (irq_ack[p]),
            .irq  (irq_out[p]),
            .rise (irq_rise[p])
        );

        assign evt[p] = data_fall[p] | (irq_rise[p] & main_pwr_ok);
    end

    kbm_wake_regs u_regs (
        .clk      (clk),
        .sb_rst   (sb_rst),
        .main_rst (main_rst),
        .wr_en    (wr_en),
        .wr_sel   (kbm_sel_e'(wr_sel)),
        .wr_data  (wr_data),
        .evt      (evt),
        .cfg      (cfg),
        .sts      (sts)
    );

    assign core_kbd_clk   = out_clk[PORT_KBD];
    assign core_kbd_dat   = out_dat[PORT_KBD];
    assign core_mouse_clk = out_clk[PORT_MOUSE];
    assign core_mouse_dat = out_dat[PORT_MOUSE];
    assign kbd_irq        = irq_out[PORT_KBD];
    assign mouse_irq      = irq_out[PORT_MOUSE];
    assign core_rst       = cfg.core_rst;

    always_comb begin
        wake_sts = '0;
        for (int p = 0; p < NPORT; p++) wake_sts[evt_bit(p)] = sts[p];
    end

    assign pme = cfg.pme_en & |(sts & cfg.wake_en);

endmodule

// File: rtl/kbm_wake_chk.sv
module kbm_wake_chk
    import kbm_wake_pkg::*;
(
    input logic             clk,
    input logic             sb_rst,
    input logic             main_rst,
    input logic             main_pwr_ok,
    input logic             wr_en,
    input logic [2:0]       wr_sel,
    input logic [7:0]       wr_data,
    input logic             kbd_irq_ack,
    input logic             mouse_irq_ack,
    input logic             kbd_irq,
    input logic             mouse_irq,
    input logic             core_rst,
    input logic [7:0]       wake_sts,
    input logic             pme,
    input kbm_cfg_t         cfg,
    input logic [NPORT-1:0] data_fall
);
    // R3
    iso_keep_chk: assert property (@(posedge clk) disable iff (sb_rst)
        (main_rst && !wr_en) |=> $stable(cfg.iso));

    // R5
    kbd_ack_chk: assert property (@(posedge clk) disable iff (main_rst)
        kbd_irq_ack |=> !kbd_irq);

    // R5
    mouse_ack_chk: assert property (@(posedge clk) disable iff (main_rst)
        mouse_irq_ack |=> !mouse_irq);

    // R7
    stby_edge_chk: assert property (@(posedge clk) disable iff (sb_rst)
        ($rose(wake_sts[3]) && !$past(main_pwr_ok)) |-> $past(data_fall[PORT_KBD]));

    // R8
    sts_hold_chk: assert property (@(posedge clk) disable iff (sb_rst)
        (wake_sts[3] && !(wr_en && wr_sel == 3'd2 && wr_data[3])) |=> wake_sts[3]);

    // R9
    pme_src_chk: assert property (@(posedge clk) disable iff (sb_rst)
        pme |-> (cfg.pme_en && (wake_sts[3] || wake_sts[4])));

    // R10
    core_rst_chk: assert property (@(posedge clk) disable iff (main_rst)
        !$past(wr_en && wr_sel == 3'd4) |-> $stable(core_rst));

endmodule

bind kbm_wake_iso kbm_wake_chk u_chk (.*);

// File: tb/test_kbm_wake_iso.sv
module test_kbm_wake_iso;

    logic       clk = 1'b0;
    logic       sb_rst, main_rst, main_pwr_ok;
    logic       wr_en;
    logic [2:0] wr_sel;
    logic [7:0] wr_data;
    logic       kbd_clk_pin, kbd_dat_pin, mouse_clk_pin, mouse_dat_pin;
    logic       core_kbd_clk, core_kbd_dat, core_mouse_clk, core_mouse_dat;
    logic       kbd_irq_raw, mouse_irq_raw, kbd_irq_ack, mouse_irq_ack;
    logic       kbd_irq, mouse_irq, core_rst, pme;
    logic [7:0] wake_sts;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    kbm_wake_iso i_kbm_wake_iso (.*);

    typedef struct packed {
        logic g, ek, em, sk, sm, exp_pme;
    } pv_t;

    localparam pv_t PV [8] = '{
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] sel, logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic both_reset();
        sb_rst = 1'b1; main_rst = 1'b1;
        tick(2);
        sb_rst = 1'b0; main_rst = 1'b0;
    endtask

    task automatic main_reset();
        main_rst = 1'b1;
        tick(2);
        main_rst = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        sb_rst = 1'b1; main_rst = 1'b1; main_pwr_ok = 1'b1;
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        kbd_clk_pin = 1'b1; kbd_dat_pin = 1'b1;
        mouse_clk_pin = 1'b1; mouse_dat_pin = 1'b1;
        kbd_irq_raw = 1'b0; mouse_irq_raw = 1'b0;
        kbd_irq_ack = 1'b0; mouse_irq_ack = 1'b0;
        @(negedge clk);

        // R9 / R6: PME table
        for (int i = 0; i < 8; i++) begin
            both_reset();
            wr(3'd3, {3'b000, PV[i].em, PV[i].ek, 2'b00, PV[i].g});
            kbd_dat_pin   = ~PV[i].sk;
            mouse_dat_pin = ~PV[i].sm;
            tick(4);
            kbd_dat_pin = 1'b1; mouse_dat_pin = 1'b1;
            tick(1);
            chk("R9 pme", {7'd0, pme}, {7'd0, PV[i].exp_pme});
            chk("R6 status", wake_sts, {3'b000, PV[i].sm, PV[i].sk, 3'b000});
        end

        // R11 reset state
        both_reset();
        tick(2);
        chk("R11 status", wake_sts, 8'h00);
        chk("R11 outputs", {4'd0, pme, core_rst, kbd_irq, mouse_irq}, 8'h00);

        // R1 isolation
        kbd_clk_pin = 1'b0; kbd_dat_pin = 1'b0;
        mouse_clk_pin = 1'b0; mouse_dat_pin = 1'b0;
        #1;
        chk("R1 pass", {4'd0, core_kbd_clk, core_kbd_dat, core_mouse_clk, core_mouse_dat}, 8'h00);
        wr(3'd0, 8'h20);
        chk("R1 kbd iso", {4'd0, core_kbd_clk, core_kbd_dat, core_mouse_clk, core_mouse_dat}, 8'h0c);
        wr(3'd0, 8'h40);
        chk("R1 mouse iso", {4'd0, core_kbd_clk, core_kbd_dat, core_mouse_clk, core_mouse_dat}, 8'h03);
        kbd_clk_pin = 1'b1; kbd_dat_pin = 1'b1;
        mouse_clk_pin = 1'b1; mouse_dat_pin = 1'b1;

        // R2 wake sees isolated data
        both_reset();
        wr(3'd0, 8'h60);
        kbd_dat_pin = 1'b0; mouse_dat_pin = 1'b0;
        tick(4);
        chk("R2 status", wake_sts, 8'h18);
        chk("R2 core lines", {6'd0, core_kbd_dat, core_mouse_dat}, 8'h03);
        kbd_dat_pin = 1'b1; mouse_dat_pin = 1'b1;

        // R3 survive main reset
        kbd_clk_pin = 1'b0; mouse_clk_pin = 1'b0;
        main_reset();
        chk("R3 iso kept", {6'd0, core_kbd_clk, core_mouse_clk}, 8'h03);
        chk("R3 status kept", wake_sts, 8'h18);
        both_reset();
        chk("R3 iso cleared", {6'd0, core_kbd_clk, core_mouse_clk}, 8'h00);
        kbd_clk_pin = 1'b1; mouse_clk_pin = 1'b1;

        // R6 data low at power-up
        kbd_dat_pin = 1'b0;
        both_reset();
        tick(4);
        chk("R6 power-up low", wake_sts, 8'h08);
        kbd_dat_pin = 1'b1;

        // R7 power gating
        both_reset();
        tick(2);
        main_pwr_ok = 1'b0;
        kbd_irq_raw = 1'b1;
        tick(2);
        kbd_irq_raw = 1'b0;
        tick(1);
        chk("R7 irq no main", wake_sts, 8'h00);
        mouse_dat_pin = 1'b0;
        tick(4);
        mouse_dat_pin = 1'b1;
        chk("R7 edge no main", wake_sts, 8'h10);
        main_pwr_ok = 1'b1;
        kbd_irq_raw = 1'b1;
        tick(1);
        kbd_irq_raw = 1'b0;
        chk("R7 irq main", wake_sts, 8'h18);

        // R8 write-one-to-clear
        wr(3'd2, 8'h08);
        chk("R8 clear", wake_sts, 8'h10);
        kbd_irq_raw = 1'b1;
        tick(1);
        kbd_irq_raw = 1'b0;
        tick(1);
        chk("R8 reset by irq", wake_sts, 8'h18);
        kbd_irq_raw = 1'b1;
        wr(3'd2, 8'h08);
        kbd_irq_raw = 1'b0;
        chk("R8 set wins", wake_sts, 8'h18);
        wr(3'd2, 8'h18);
        chk("R8 clear both", wake_sts, 8'h00);

        // R4 mode 0
        main_reset();
        kbd_irq_raw = 1'b1;
        #1;
        chk("R4 masked before latch", {7'd0, kbd_irq}, 8'h00);
        tick(1);
        chk("R4 raw and latch", {7'd0, kbd_irq}, 8'h01);
        kbd_irq_raw = 1'b0;
        #1;
        chk("R4 raw low", {7'd0, kbd_irq}, 8'h00);

        // R5 mode 1
        tick(1);
        wr(3'd1, 8'h08);
        chk("R5 latched shown", {7'd0, kbd_irq}, 8'h01);
        kbd_irq_ack = 1'b1;
        tick(1);
        kbd_irq_ack = 1'b0;
        chk("R5 ack clears", {7'd0, kbd_irq}, 8'h00);
        kbd_irq_raw = 1'b1;
        tick(1);
        kbd_irq_raw = 1'b0;
        tick(1);
        chk("R5 held", {7'd0, kbd_irq}, 8'h01);
        kbd_irq_raw = 1'b1; kbd_irq_ack = 1'b1;
        tick(1);
        kbd_irq_raw = 1'b0; kbd_irq_ack = 1'b0;
        chk("R5 ack priority", {7'd0, kbd_irq}, 8'h00);
        wr(3'd1, 8'h18);
        mouse_irq_raw = 1'b1;
        tick(1);
        mouse_irq_raw = 1'b0;
        tick(1);
        chk("R5 mouse held", {7'd0, mouse_irq}, 8'h01);

        // R10 core reset
        wr(3'd4, 8'h40);
        chk("R10 set", {7'd0, core_rst}, 8'h01);
        wr(3'd1, 8'h00);
        chk("R10 sticky", {7'd0, core_rst}, 8'h01);
        wr(3'd4, 8'h00);
        chk("R10 cleared", {7'd0, core_rst}, 8'h00);
        wr(3'd4, 8'h40);
        main_reset();
        chk("R10 main reset", {7'd0, core_rst}, 8'h00);

        done = 1;
        summary();
    end

endmodule